// File: doc/BRIEF.md
# Mixed-Width Dual-Port 18-Kbit Block RAM

This block models one 18-Kbit embedded memory with two ports that share a single storage array. The array holds 2048 nine-bit cells. Each cell is eight data bits plus one extra bit meant for parity. Each port has its own width, chosen by parameter from the shapes 1, 2, 4, 9, 18 and 36 bits. Both ports see the same bits through a fixed mapping. Words are laid out from the least significant bit of word 0 upward, so a narrow port can read back what a wide port wrote.

Each port has enable, write-enable and per-lane write strobes, and all of them are sampled on the clock edge. A read returns the stored word after that edge. An optional output register adds one more stage, with its own clock enable. Writes follow the "normal" policy: a write cycle leaves the read output untouched. The contents can be preloaded from a parameter image. A read-only parameter then blocks every write, so the block serves as a ROM. In pseudo dual-port use, port B only reads, and port A may then use the 36-bit shape.

Top module: `bram_dp18k`

## Requirements
- R1: Port widths are limited to 1, 2, 4, 9, 18 and 36, and an illegal width stops elaboration. With `TRUE_DUAL=1` both ports must be at most 18 bits wide. With `TRUE_DUAL=0`, port B ignores `we_b` and treats every enabled cycle as a read.
- R2: Cell c holds data bits 7:0 and a parity bit in bit 8. For a 1-, 2- or 4-bit port, word n sits in cell n/(8/W) at bit offset (n mod (8/W))*W. For a 9-, 18- or 36-bit port with L=W/9 lanes, word n spans cells n*L through n*L+L-1. Port bits 9k+8 down to 9k map to cell n*L+k, with port bit 9k+8 being that cell's parity bit.
- R3: Writes from 1-, 2- or 4-bit ports never change a parity bit.
- R4: For 18- and 36-bit ports, `be_x[k]` enables the write of lane k. For narrower ports the strobes are ignored and the whole word is written.
- R5: Without an output register, read data appears after the clock edge that samples `en_x=1, we_x=0`. With the output register, it appears one edge later, provided `oce_x=1` on that edge.
- R6: A write cycle or an idle cycle leaves the read stage of that port unchanged.
- R7: When one port writes a location that the other port reads in the same cycle, the reader gets the contents from before the write.
- R8: `rst_x` clears both read stages of port x to zero on the next edge. It takes priority over a read and leaves the array untouched.
- R9: With the output register present, `oce_x=0` holds that register's value.
- R10: The array starts with the contents of `INIT`, where cell c is `INIT[9c+8:9c]`. With `ROM_MODE=1`, no write changes the array and a write cycle does not update the output.
- R11: When both ports write different bits of one cell in the same cycle, both writes take effect. Writing the same bit from both ports in one cycle is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_a | input | 1 | Port A synchronous clear of the read stages |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write select (1 write, 0 read) |
| be_a | input | 4 | Port A lane write strobes |
| addr_a | input | log2(depth A) | Port A word address |
| wdata_a | input | WIDTH_A | Port A write word |
| oce_a | input | 1 | Port A output register clock enable |
| rdata_a | output | WIDTH_A | Port A read word |
| rst_b | input | 1 | Port B synchronous clear of the read stages |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write select |
| be_b | input | 4 | Port B lane write strobes |
| addr_b | input | log2(depth B) | Port B word address |
| wdata_b | input | WIDTH_B | Port B write word |
| oce_b | input | 1 | Port B output register clock enable |
| rdata_b | output | WIDTH_B | Port B read word |

## Verification
A wrong lane index or mask in the mapping corrupts neighbouring bits. This shows up on the next read through the other port, because that port addresses the same cells at a different width. A read stage that updates when it should not changes `rdata` one edge after a write or idle cycle, or one edge after the output register was held. The bench compares every port output on every cycle against a cell-level model, so such errors surface within one or two clocks of the next access to that cell.

// File: rtl/bram_pkg.sv
package bram_pkg;

   localparam int CELLS   = 2048;
   localparam int CELL_W  = 9;
   localparam int DATA_W  = 8;
   localparam int LANES   = 4;
   localparam int IDX_W   = $clog2(CELLS);
   localparam int IMAGE_W = CELLS * CELL_W;

   typedef logic [CELL_W-1:0] cell_t;
   typedef logic [IDX_W-1:0]  idx_t;

   function automatic bit legal_width(int w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
   endfunction

   function automatic int word_count(int w);
      return (w < CELL_W) ? (CELLS * DATA_W) / w : CELLS / (w / CELL_W);
   endfunction

   function automatic int addr_bits(int w);
      return $clog2(word_count(w));
   endfunction

   function automatic int lane_count(int w);
      return (w < CELL_W) ? 1 : w / CELL_W;
   endfunction

   function automatic int sub_shift(int w);
      return (w < CELL_W) ? $clog2(DATA_W / w) : 0;
   endfunction

endpackage

// File: rtl/bram_lane_map.sv
module bram_lane_map #(
   parameter int WIDTH = 18
) (
   input  logic [bram_pkg::addr_bits(WIDTH)-1:0] addr,
   input  logic [WIDTH-1:0]                      wdata,
   input  logic [bram_pkg::LANES-1:0]            be,
   output bram_pkg::idx_t                        idx   [bram_pkg::LANES],
   output bram_pkg::cell_t                       mask  [bram_pkg::LANES],
   output bram_pkg::cell_t                       wcell [bram_pkg::LANES],
   output logic [2:0]                            ofs
);
   import bram_pkg::*;

   localparam int L  = lane_count(WIDTH);
   localparam int SH = sub_shift(WIDTH);

   logic unused_be;
   assign unused_be = ^be;

   generate
      if (WIDTH < CELL_W) begin : g_sub
         assign ofs = 3'(addr[SH-1:0]) * 3'(WIDTH);
      end else begin : g_full
         assign ofs = '0;
      end

      for (genvar k = 0; k < LANES; k++) begin : g_lane
         if (WIDTH < CELL_W && k == 0) begin : g_bits
            assign idx[k]   = idx_t'(addr >> SH);
            assign mask[k]  = cell_t'({WIDTH{1'b1}}) << ofs;
            assign wcell[k] = cell_t'(wdata) << ofs;
         end else if (WIDTH >= CELL_W && k < L) begin : g_cell
            assign idx[k]   = idx_t'(int'(addr) * L + k);
            assign mask[k]  = (WIDTH == CELL_W || be[k]) ? '1 : '0;
            assign wcell[k] = wdata[CELL_W*k +: CELL_W];
         end else begin : g_none
            assign idx[k]   = '0;
            assign mask[k]  = '0;
            assign wcell[k] = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/bram_array.sv
module bram_array #(
   parameter logic [bram_pkg::IMAGE_W-1:0] INIT = '0
) (
   input  logic            clk,
   input  logic            wr_a,
   input  bram_pkg::idx_t  idx_a   [bram_pkg::LANES],
   input  bram_pkg::cell_t mask_a  [bram_pkg::LANES],
   input  bram_pkg::cell_t wcell_a [bram_pkg::LANES],
   input  logic            wr_b,
   input  bram_pkg::idx_t  idx_b   [bram_pkg::LANES],
   input  bram_pkg::cell_t mask_b  [bram_pkg::LANES],
   input  bram_pkg::cell_t wcell_b [bram_pkg::LANES],
   output bram_pkg::cell_t rcell_a [bram_pkg::LANES],
   output bram_pkg::cell_t rcell_b [bram_pkg::LANES]
);
   import bram_pkg::*;

   cell_t store [CELLS];
   cell_t amask [LANES];
   cell_t adata [LANES];

   initial begin
      for (int i = 0; i < CELLS; i++) store[i] = INIT[i*CELL_W +: CELL_W];
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_rd
         assign rcell_a[k] = store[idx_a[k]];
         assign rcell_b[k] = store[idx_b[k]];
      end
   endgenerate

   // bits of a port-A write that land in a cell port B also writes
   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         amask[k] = '0;
         adata[k] = '0;
         for (int j = 0; j < LANES; j++) begin
            if (wr_a && idx_a[j] == idx_b[k]) begin
               amask[k] = amask[k] | mask_a[j];
               adata[k] = adata[k] | (wcell_a[j] & mask_a[j]);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int j = 0; j < LANES; j++) begin
         if (wr_a && mask_a[j] != '0)
            store[idx_a[j]] <= (store[idx_a[j]] & ~mask_a[j]) | (wcell_a[j] & mask_a[j]);
      end
      for (int k = 0; k < LANES; k++) begin
         if (wr_b && mask_b[k] != '0)
            store[idx_b[k]] <= (store[idx_b[k]] & ~(mask_b[k] | amask[k]))
                             | (wcell_b[k] & mask_b[k])
                             | (adata[k] & ~mask_b[k]);
      end
   end

endmodule

// File: rtl/bram_read_port.sv
module bram_read_port #(
   parameter int WIDTH   = 18,
   parameter bit OUT_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            rd,
   input  logic            oce,
   input  logic [2:0]      ofs,
   input  bram_pkg::cell_t rcell [bram_pkg::LANES],
   output logic [WIDTH-1:0] rdata
);
   import bram_pkg::*;

   localparam int L = lane_count(WIDTH);

   logic [WIDTH-1:0] word;
   logic [WIDTH-1:0] held;
   logic             unused_sig;

   generate
      if (WIDTH < CELL_W) begin : g_sub
         assign word = WIDTH'(rcell[0] >> ofs);
         assign unused_sig = ^{rcell[1], rcell[2], rcell[3], oce};
      end else begin : g_full
         for (genvar k = 0; k < L; k++) begin : g_lane
            assign word[CELL_W*k +: CELL_W] = rcell[k];
         end
         assign unused_sig = ^{ofs, oce};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      held <= '0;
      else if (rd)  held <= word;
   end

   generate
      if (OUT_REG) begin : g_oreg
         logic [WIDTH-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)       q <= '0;
            else if (oce)  q <= held;
         end
         assign rdata = q;
      end else begin : g_direct
         assign rdata = held;
      end
   endgenerate

endmodule

// File: rtl/bram_dp18k.sv
module bram_dp18k #(
   parameter int WIDTH_A   = 18,
   parameter int WIDTH_B   = 18,
   parameter bit TRUE_DUAL = 1'b1,
   parameter bit OUT_REG_A = 1'b0,
   parameter bit OUT_REG_B = 1'b0,
   parameter bit ROM_MODE  = 1'b0,
   parameter logic [bram_pkg::IMAGE_W-1:0] INIT = '0
) (
   input  logic                                   clk,
   input  logic                                   rst_a,
   input  logic                                   en_a,
   input  logic                                   we_a,
   input  logic [3:0]                             be_a,
   input  logic [bram_pkg::addr_bits(WIDTH_A)-1:0] addr_a,
   input  logic [WIDTH_A-1:0]                     wdata_a,
   input  logic                                   oce_a,
   output logic [WIDTH_A-1:0]                     rdata_a,
   input  logic                                   rst_b,
   input  logic                                   en_b,
   input  logic                                   we_b,
   input  logic [3:0]                             be_b,
   input  logic [bram_pkg::addr_bits(WIDTH_B)-1:0] addr_b,
   input  logic [WIDTH_B-1:0]                     wdata_b,
   input  logic                                   oce_b,
   output logic [WIDTH_B-1:0]                     rdata_b
);
   import bram_pkg::*;

   generate
      if (!legal_width(WIDTH_A) || !legal_width(WIDTH_B)) begin : g_bad_width
         $error("bram_dp18k: port width must be 1, 2, 4, 9, 18 or 36");
      end
      if (TRUE_DUAL && (WIDTH_A > 18 || WIDTH_B > 18)) begin : g_bad_dual
         $error("bram_dp18k: two writable ports are limited to 18 bits");
      end
   endgenerate

   logic  wr_a, wr_b, rd_a, rd_b;
   idx_t  idx_a [LANES];
   idx_t  idx_b [LANES];
   cell_t mask_a [LANES];
   cell_t mask_b [LANES];
   cell_t wcell_a [LANES];
   cell_t wcell_b [LANES];
   cell_t rcell_a [LANES];
   cell_t rcell_b [LANES];
   logic [2:0] ofs_a, ofs_b;

   assign wr_a = en_a && we_a && !ROM_MODE;
   assign rd_a = en_a && !we_a;
   assign wr_b = en_b && we_b && TRUE_DUAL && !ROM_MODE;
   assign rd_b = en_b && (!we_b || !TRUE_DUAL);

   bram_lane_map #(.WIDTH(WIDTH_A)) u_map_a (
      .addr(addr_a), .wdata(wdata_a), .be(be_a),
      .idx(idx_a), .mask(mask_a), .wcell(wcell_a), .ofs(ofs_a)
   );

   bram_lane_map #(.WIDTH(WIDTH_B)) u_map_b (
      .addr(addr_b), .wdata(wdata_b), .be(be_b),
      .idx(idx_b), .mask(mask_b), .wcell(wcell_b), .ofs(ofs_b)
   );

   bram_array #(.INIT(INIT)) u_array (
      .clk(clk),
      .wr_a(wr_a), .idx_a(idx_a), .mask_a(mask_a), .wcell_a(wcell_a),
      .wr_b(wr_b), .idx_b(idx_b), .mask_b(mask_b), .wcell_b(wcell_b),
      .rcell_a(rcell_a), .rcell_b(rcell_b)
   );

   bram_read_port #(.WIDTH(WIDTH_A), .OUT_REG(OUT_REG_A)) u_rport_a (
      .clk(clk), .rst(rst_a), .rd(rd_a), .oce(oce_a),
      .ofs(ofs_a), .rcell(rcell_a), .rdata(rdata_a)
   );

   bram_read_port #(.WIDTH(WIDTH_B), .OUT_REG(OUT_REG_B)) u_rport_b (
      .clk(clk), .rst(rst_b), .rd(rd_b), .oce(oce_b),
      .ofs(ofs_b), .rcell(rcell_b), .rdata(rdata_b)
   );

endmodule

// File: rtl/bram_dp18k_chk.sv
module bram_dp18k_chk #(
   parameter int WIDTH_A   = 18,
   parameter int WIDTH_B   = 18,
   parameter bit OUT_REG_A = 1'b0,
   parameter bit OUT_REG_B = 1'b0
) (
   input logic               clk,
   input logic               rst_a,
   input logic               rst_b,
   input logic               rd_a,
   input logic               rd_b,
   input logic               oce_a,
   input logic               oce_b,
   input logic               wr_a,
   input logic               wr_b,
   input bram_pkg::idx_t     idx_a  [bram_pkg::LANES],
   input bram_pkg::cell_t    mask_a [bram_pkg::LANES],
   input bram_pkg::idx_t     idx_b  [bram_pkg::LANES],
   input bram_pkg::cell_t    mask_b [bram_pkg::LANES],
   input logic [WIDTH_A-1:0] rdata_a,
   input logic [WIDTH_B-1:0] rdata_b
);
   import bram_pkg::*;

   logic clash;
   logic unused_chk;
   assign unused_chk = ^{oce_a, oce_b, rd_a, rd_b};

   always_comb begin
      clash = 1'b0;
      for (int j = 0; j < LANES; j++)
         for (int k = 0; k < LANES; k++)
            if (idx_a[j] == idx_b[k] && (mask_a[j] & mask_b[k]) != '0) clash = 1'b1;
   end

   // R11: both ports may not write one bit in the same cycle
   p_no_bit_clash_r11: assert property (@(posedge clk) disable iff (rst_a || rst_b)
      (wr_a && wr_b) |-> !clash);

   // R8: the cycle after reset is released shows zero
   p_reset_zero_a_r8: assert property (@(posedge clk) disable iff (rst_a)
      $fell(rst_a) |-> (rdata_a == '0));
   p_reset_zero_b_r8: assert property (@(posedge clk) disable iff (rst_b)
      $fell(rst_b) |-> (rdata_b == '0));

   generate
      if (OUT_REG_A) begin : g_hold_a
         // R9: output register holds while its enable is low
         p_oreg_hold_a_r9: assert property (@(posedge clk) disable iff (rst_a)
            !oce_a |=> $stable(rdata_a));
      end else begin : g_quiet_a
         // R6: write or idle cycles leave the output alone
         p_quiet_a_r6: assert property (@(posedge clk) disable iff (rst_a)
            !rd_a |=> $stable(rdata_a));
      end
      if (OUT_REG_B) begin : g_hold_b
         p_oreg_hold_b_r9: assert property (@(posedge clk) disable iff (rst_b)
            !oce_b |=> $stable(rdata_b));
      end else begin : g_quiet_b
         p_quiet_b_r6: assert property (@(posedge clk) disable iff (rst_b)
            !rd_b |=> $stable(rdata_b));
      end
   endgenerate

endmodule

bind bram_dp18k bram_dp18k_chk #(
   .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B),
   .OUT_REG_A(OUT_REG_A), .OUT_REG_B(OUT_REG_B)
) u_chk (
   .clk(clk), .rst_a(rst_a), .rst_b(rst_b),
   .rd_a(rd_a), .rd_b(rd_b), .oce_a(oce_a), .oce_b(oce_b),
   .wr_a(wr_a), .wr_b(wr_b),
   .idx_a(idx_a), .mask_a(mask_a), .idx_b(idx_b), .mask_b(mask_b),
   .rdata_a(rdata_a), .rdata_b(rdata_b)
);

// File: tb/sim_bram_dp18k.sv
`timescale 1ns/1ps
module sim_bram_dp18k;

   function automatic logic [18431:0] make_img();
      logic [18431:0] v;
      for (int i = 0; i < 2048; i++) v[i*9 +: 9] = 9'((i * 37 + 11) ^ (i >> 2));
      return v;
   endfunction

   localparam logic [18431:0] IMG = make_img();

   logic clk = 1'b0;
   always #2 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;

   // u0: x18 / x4, both writable, output register on port B only
   logic a0_rst, a0_en, a0_we, a0_oce; logic [3:0] a0_be; logic [9:0]  a0_addr;
   logic [17:0] a0_wd, a0_rd;
   logic b0_rst, b0_en, b0_we, b0_oce; logic [3:0] b0_be; logic [11:0] b0_addr;
   logic [3:0]  b0_wd, b0_rd;
   // u1: x36 / x9, pseudo dual, ROM, output register on port A
   logic a1_rst, a1_en, a1_we, a1_oce; logic [3:0] a1_be; logic [8:0]  a1_addr;
   logic [35:0] a1_wd, a1_rd;
   logic b1_rst, b1_en, b1_we, b1_oce; logic [3:0] b1_be; logic [10:0] b1_addr;
   logic [8:0]  b1_wd, b1_rd;
   // u2: x1 / x2, both writable, zero image
   logic a2_rst, a2_en, a2_we, a2_oce; logic [3:0] a2_be; logic [13:0] a2_addr;
   logic [0:0]  a2_wd, a2_rd;
   logic b2_rst, b2_en, b2_we, b2_oce; logic [3:0] b2_be; logic [12:0] b2_addr;
   logic [1:0]  b2_wd, b2_rd;

   bram_dp18k #(.WIDTH_A(18), .WIDTH_B(4), .TRUE_DUAL(1), .OUT_REG_A(0), .OUT_REG_B(1),
                .ROM_MODE(0), .INIT(IMG)) u0 (
      .clk(clk), .rst_a(a0_rst), .en_a(a0_en), .we_a(a0_we), .be_a(a0_be), .addr_a(a0_addr),
      .wdata_a(a0_wd), .oce_a(a0_oce), .rdata_a(a0_rd),
      .rst_b(b0_rst), .en_b(b0_en), .we_b(b0_we), .be_b(b0_be), .addr_b(b0_addr),
      .wdata_b(b0_wd), .oce_b(b0_oce), .rdata_b(b0_rd));

   bram_dp18k #(.WIDTH_A(36), .WIDTH_B(9), .TRUE_DUAL(0), .OUT_REG_A(1), .OUT_REG_B(0),
                .ROM_MODE(1), .INIT(IMG)) u1 (
      .clk(clk), .rst_a(a1_rst), .en_a(a1_en), .we_a(a1_we), .be_a(a1_be), .addr_a(a1_addr),
      .wdata_a(a1_wd), .oce_a(a1_oce), .rdata_a(a1_rd),
      .rst_b(b1_rst), .en_b(b1_en), .we_b(b1_we), .be_b(b1_be), .addr_b(b1_addr),
      .wdata_b(b1_wd), .oce_b(b1_oce), .rdata_b(b1_rd));

   bram_dp18k #(.WIDTH_A(1), .WIDTH_B(2), .TRUE_DUAL(1), .OUT_REG_A(0), .OUT_REG_B(0),
                .ROM_MODE(0), .INIT('0)) u2 (
      .clk(clk), .rst_a(a2_rst), .en_a(a2_en), .we_a(a2_we), .be_a(a2_be), .addr_a(a2_addr),
      .wdata_a(a2_wd), .oce_a(a2_oce), .rdata_a(a2_rd),
      .rst_b(b2_rst), .en_b(b2_en), .we_b(b2_we), .be_b(b2_be), .addr_b(b2_addr),
      .wdata_b(b2_wd), .oce_b(b2_oce), .rdata_b(b2_rd));

   // cell-level reference, one image per instance
   logic [8:0] ref_mem [3][2048];
   logic [17:0] exp_a0;
   logic [3:0]  lat_b0, out_b0;

   function automatic logic [35:0] ref_rd(int inst, int w, int addr);
      logic [35:0] r = '0;
      if (w < 9) begin
         int per = 8 / w;
         logic [8:0] c = ref_mem[inst][addr / per];
         for (int b = 0; b < w; b++) r[b] = c[(addr % per) * w + b];
      end else begin
         for (int k = 0; k < w / 9; k++) r[9*k +: 9] = ref_mem[inst][addr * (w / 9) + k];
      end
      return r;
   endfunction

   task automatic ref_wr(int inst, int w, int addr, logic [35:0] d, logic [3:0] be);
      if (w < 9) begin
         int per = 8 / w;
         for (int b = 0; b < w; b++) ref_mem[inst][addr / per][(addr % per) * w + b] = d[b];
      end else begin
         for (int k = 0; k < w / 9; k++)
            if (w < 18 || be[k]) ref_mem[inst][addr * (w / 9) + k] = d[9*k +: 9];
      end
   endtask

   task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic step0(input logic ra, input logic ea, input logic wa, input logic [3:0] bea,
                        input int aa, input logic [17:0] da,
                        input logic rb, input logic eb, input logic wb, input int ab,
                        input logic [3:0] db, input logic ob, input string tag);
      logic [35:0] va, vb;
      a0_rst = ra; a0_en = ea; a0_we = wa; a0_be = bea; a0_addr = 10'(aa); a0_wd = da;
      b0_rst = rb; b0_en = eb; b0_we = wb; b0_addr = 12'(ab); b0_wd = db; b0_oce = ob;
      va = ref_rd(0, 18, aa);
      vb = ref_rd(0, 4, ab);
      if (ra) exp_a0 = '0; else if (ea && !wa) exp_a0 = va[17:0];
      if (rb) begin out_b0 = '0; lat_b0 = '0; end
      else begin
         if (ob) out_b0 = lat_b0;
         if (eb && !wb) lat_b0 = vb[3:0];
      end
      if (ea && wa) ref_wr(0, 18, aa, 36'(da), bea);
      if (eb && wb) ref_wr(0, 4, ab, 36'(db), 4'h0);
      tick();
      chk({tag, " port A"}, 36'(a0_rd), 36'(exp_a0));
      chk({tag, " port B"}, 36'(b0_rd), 36'(out_b0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int seed = 7;
      void'($urandom(seed));
      for (int i = 0; i < 2048; i++) begin
         ref_mem[0][i] = IMG[i*9 +: 9];
         ref_mem[1][i] = IMG[i*9 +: 9];
         ref_mem[2][i] = '0;
      end
      exp_a0 = '0; lat_b0 = '0; out_b0 = '0;
      {a0_rst, a0_en, a0_we, a0_oce, a0_be, a0_addr, a0_wd} = '0;
      {b0_rst, b0_en, b0_we, b0_oce, b0_addr, b0_wd} = '0; b0_be = 4'hF;
      {a1_en, a1_we, a1_be, a1_addr, a1_wd} = '0; a1_oce = 1'b1; a1_rst = 1'b1;
      {b1_en, b1_we, b1_be, b1_addr, b1_wd, b1_oce} = '0; b1_rst = 1'b1;
      {a2_en, a2_we, a2_be, a2_addr, a2_wd, a2_oce} = '0; a2_rst = 1'b1;
      {b2_en, b2_we, b2_be, b2_addr, b2_wd, b2_oce} = '0; b2_rst = 1'b1;

      // R8: reset clears both read stages, also over a read request
      step0(1, 1, 0, 4'h3, 5, '0, 1, 1, 0, 9, '0, 1, "R8 reset with read");
      step0(1, 0, 0, 4'h3, 0, '0, 1, 0, 0, 0, '0, 1, "R8 reset hold");
      a1_rst = 0; b1_rst = 0; a2_rst = 0; b2_rst = 0;
      chk("R8 u1 port A after reset", 36'(a1_rd), '0);
      chk("R8 u2 port B after reset", 36'(b2_rd), '0);

      // R10: preloaded contents, R5: latency on each port
      step0(0, 1, 0, 4'h3, 5, '0, 0, 1, 0, 100, '0, 1, "R10 preload read R5 latency");
      step0(0, 0, 0, 4'h3, 5, '0, 0, 0, 0, 100, '0, 1, "R5 second stage");
      // R9: output register hold
      step0(0, 0, 0, 4'h3, 0, '0, 0, 1, 0, 201, '0, 0, "R9 read with oce low");
      step0(0, 0, 0, 4'h3, 0, '0, 0, 0, 0, 0, '0, 0, "R9 hold");
      step0(0, 0, 0, 4'h3, 0, '0, 0, 0, 0, 0, '0, 1, "R9 release");
      // R4 and R6: lane-masked write leaves port A output alone
      step0(0, 1, 1, 4'h1, 9, 18'h2A5C3, 0, 0, 0, 0, '0, 1, "R4 R6 masked write");
      step0(0, 1, 0, 4'h3, 9, '0, 0, 0, 0, 0, '0, 1, "R4 lane strobe readback");
      // R2 R3: x4 write into cell 18, read back as x18 (parity untouched)
      step0(0, 0, 0, 4'h3, 0, '0, 0, 1, 1, 37, 4'hA, 1, "R3 narrow write");
      step0(0, 1, 0, 4'h3, 9, '0, 0, 1, 0, 36, '0, 1, "R2 R3 cross-width read");
      // R7: B reads cell 40 while A writes it
      step0(0, 1, 1, 4'h3, 20, 18'h15555, 0, 1, 0, 80, '0, 1, "R7 read during write");
      step0(0, 1, 0, 4'h3, 20, '0, 0, 0, 0, 80, '0, 1, "R7 old data then new");

      // R2 R5 R6: random mixed traffic
      for (int n = 0; n < 800; n++) begin
         logic ea = 1'($urandom), wa = 1'($urandom), eb = 1'($urandom), wb = 1'($urandom);
         int aa = $urandom_range(0, 63), ab = $urandom_range(0, 255);
         if (ea && wa && eb && wb && (ab / 2) / 2 == aa) wb = 1'b0;
         step0(0, ea, wa, 4'($urandom), aa, 18'($urandom),
               0, eb, wb, ab, 4'($urandom), 1'($urandom), "R2 R5 R6 random");
      end
      step0(0, 0, 0, 4'h0, 0, '0, 0, 0, 0, 0, '0, 1, "R6 idle");

      // R1 R5 R10: x36 / x9 pseudo dual ROM instance
      a1_en = 1; a1_addr = 7; tick();
      chk("R5 x36 first edge", 36'(a1_rd), '0);
      a1_en = 0; tick();
      chk("R1 R5 x36 read via output register", a1_rd, ref_rd(1, 36, 7));
      b1_en = 1; b1_addr = 29; tick();
      chk("R1 R5 x9 one-cycle read", 36'(b1_rd), ref_rd(1, 9, 29));
      a1_en = 1; a1_we = 1; a1_be = 4'hF; a1_wd = '0;
      b1_we = 1; b1_addr = 30; tick();
      chk("R1 pseudo-dual B ignores write select", 36'(b1_rd), ref_rd(1, 9, 30));
      a1_we = 0; b1_en = 0; tick(); a1_en = 0; tick();
      chk("R10 ROM write has no effect", a1_rd, ref_rd(1, 36, 7));

      // R11 R2: x1 and x2 write different bits of cell 0 together
      a2_en = 1; a2_we = 1; a2_addr = 1; a2_wd = 1'b1;
      b2_en = 1; b2_we = 1; b2_addr = 2; b2_wd = 2'b11;
      ref_wr(2, 1, 1, 36'h1, 4'h0); ref_wr(2, 2, 2, 36'h3, 4'h0);
      tick();
      a2_we = 0; b2_we = 0; tick();
      chk("R11 x1 bit survives joint write", 36'(a2_rd), ref_rd(2, 1, 1));
      chk("R11 x2 bits survive joint write", 36'(b2_rd), ref_rd(2, 2, 2));
      a2_addr = 0; b2_addr = 0; tick();
      chk("R2 x2 word 0 mapping", 36'(b2_rd), 36'h2);
      chk("R2 x1 word 0 mapping", 36'(a2_rd), ref_rd(2, 1, 0));
      a2_en = 0; b2_en = 0;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule